// File: doc/BRIEF.md
# Prediction-Graph Page Prefetch Engine

This engine keeps a page cache ahead of a code-fetching host. It walks a graph in which every logical block address (LBA) names the page or pages likely to be needed after it. Each time a page arrives from NAND, the engine decodes the metadata in that page's spare area. The metadata names the next LBA directly, or points into a branch table held in SRAM, or says that the walk ends here. The engine then asks for the chosen successor to be fetched into the cache queue.

The walk is greedy. The next request always comes from the successors of the page the engine requested last. When a page has several successors, the engine shares its requests among them in rotation. It keeps one rotation pointer for each branch list. A demand miss reported by the address converter moves the walk to the missed LBA at once. When the cache queue is full, the engine stops offering requests.

Top module: `pgraph_prefetch`

## Requirements
- R1: After reset, `pf_valid` and `bt_rd` are 0. No page metadata starts a walk until a demand miss has seeded one.
- R2: Spare bits [1:0] hold the node kind and bits [LBA_W+1:2] hold the payload. Kind 2'b01 means one successor, whose LBA is the payload. Kind 2'b10 means a branch, and the low BT_AW payload bits give the list start address. Kind 2'b00 means no successor. Kind 2'b11 is treated the same as 2'b00.
- R3: When a one-successor page is decoded, the engine raises `pf_valid` with `pf_lba` equal to the payload.
- R4: When a branch page is decoded, the engine reads the successor count at the start address. It then reads the successor at start+1+index. The table has one cycle of read latency. A count of 0 ends the walk.
- R5: Each branch list has its own rotation index, selected by the low bits of its start address. The index starts at 0, steps once each time the list is used, and wraps modulo the count. Repeated visits therefore prefetch every successor in list order.
- R6: The walk uses only metadata of the LBA it last requested, or of the missed LBA. Pages with any other LBA are ignored.
- R7: After a no-successor node, the engine issues nothing until the next demand miss.
- R8: A demand miss withdraws any pending request in the next cycle and restarts the walk from `miss_lba`. A miss takes precedence over page metadata in the same cycle.
- R9: While `q_full` is 1, `pf_valid` is 0. The pending target is kept and offered again once space returns.
- R10: While a request waits for `pf_ready`, `pf_lba` stays stable. The walk moves only on a cycle where `pf_valid` and `pf_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Demand miss strobe from the converter |
| miss_lba | input | LBA_W | LBA that missed |
| pg_valid | input | 1 | A page read finished and its spare data is present |
| pg_lba | input | LBA_W | LBA of the page just read |
| pg_spare | input | LBA_W+2 | Spare-area metadata of that page |
| bt_rd | output | 1 | Branch table read enable |
| bt_addr | output | BT_AW | Branch table read address |
| bt_data | input | LBA_W | Branch table read data, one cycle after `bt_rd` |
| q_full | input | 1 | Cache queue has no free slot |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Prefetch request accepted |
| pf_lba | output | LBA_W | LBA to prefetch |

## Verification
The hardest behaviour to reach is the rotation wrap (R5). It shows only when the walk comes back to the same branch page several times through pages it requested itself. The stimulus table therefore builds a loop: each successor of one branch page leads back to that page. After four visits the rotation has returned to the first successor. A second branch list with a different start address then shows that each list keeps its own rotation state. Directed steps hold `q_full` and `pf_ready` against a pending request, and drop a miss on top of it.

// File: rtl/pfe_pkg.sv
// Shared types for the prediction-graph prefetch engine.
// Assumes: the node kind sits in the two lowest spare bits.
package pfe_pkg;

    typedef enum logic [1:0] {
        KIND_END = 2'b00,
        KIND_ONE = 2'b01,
        KIND_FAN = 2'b10
    } node_kind_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_META,
        S_CNT,
        S_IDX,
        S_LBA,
        S_ISSUE
    } walk_state_t;

endpackage

// File: rtl/pfe_spare_decode.sv
// Splits spare-area metadata into node kind, successor LBA and list start.
// Assumes: kind in bits [1:0], payload above it; the reserved code 2'b11
// is reported as KIND_END so that an unknown node stops the walk.
module pfe_spare_decode
    import pfe_pkg::*;
#(
    parameter int LBA_W = 16,
    parameter int BT_AW = 8
) (
    input  logic [LBA_W+1:0] spare,
    output node_kind_t       kind,
    output logic [LBA_W-1:0] link,
    output logic [BT_AW-1:0] base
);
    // Field extraction and kind mapping.
    always_comb begin
        link = spare[LBA_W+1:2];
        base = spare[BT_AW+1:2];
        unique case (spare[1:0])
            2'b01:   kind = KIND_ONE;
            2'b10:   kind = KIND_FAN;
            default: kind = KIND_END;
        endcase
    end
endmodule

// File: rtl/pfe_rr_table.sv
// Per-branch rotation pointers. The slot is chosen by the low list-start
// bits. pick is the current index clamped below count; on advance the
// slot stores pick+1, wrapped to 0 at count.
// Assumes: count is nonzero when advance is raised.
module pfe_rr_table #(
    parameter int SLOT_W = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot,
    input  logic [CNT_W-1:0]  count,
    input  logic              advance,
    output logic [CNT_W-1:0]  pick
);
    localparam int SLOTS = 1 << SLOT_W;

    logic [CNT_W-1:0] rr_q [SLOTS];
    logic [CNT_W:0]   nxt;

    // Clamp the stored index to the current count, form its successor.
    always_comb begin
        pick = (rr_q[slot] >= count) ? '0 : rr_q[slot];
        nxt  = {1'b0, pick} + 1'b1;
        if (nxt == {1'b0, count}) nxt = '0;
    end

    // Pointer storage, one entry per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) rr_q[i] <= '0;
        end else if (advance) begin
            rr_q[slot] <= nxt[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/pgraph_prefetch.sv
// Prediction-graph page prefetch engine. Follows successor links of the
// last requested page and offers one prefetch at a time on a valid/ready
// port. A branch list costs two table reads (count, then entry).
// Assumes: the branch table has one cycle of read latency; list entries
// fit below 2**BT_AW; counts fit in CNT_W bits of the count word.
module pgraph_prefetch
    import pfe_pkg::*;
#(
    parameter int LBA_W  = 16,
    parameter int BT_AW  = 8,
    parameter int CNT_W  = 4,
    parameter int SLOT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [LBA_W-1:0] miss_lba,
    input  logic             pg_valid,
    input  logic [LBA_W-1:0] pg_lba,
    input  logic [LBA_W+1:0] pg_spare,
    output logic             bt_rd,
    output logic [BT_AW-1:0] bt_addr,
    input  logic [LBA_W-1:0] bt_data,
    input  logic             q_full,
    output logic             pf_valid,
    input  logic             pf_ready,
    output logic [LBA_W-1:0] pf_lba
);
    walk_state_t      state;
    logic [LBA_W-1:0] cur_lba, tgt_lba;
    logic [BT_AW-1:0] base_q;
    node_kind_t       dec_kind;
    logic [LBA_W-1:0] dec_link;
    logic [BT_AW-1:0] dec_base;
    logic [CNT_W-1:0] cnt, pick;
    logic             rr_adv, meta_hit;

    pfe_spare_decode #(.LBA_W(LBA_W), .BT_AW(BT_AW)) u_dec (
        .spare(pg_spare), .kind(dec_kind), .link(dec_link), .base(dec_base)
    );

    pfe_rr_table #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_rr (
        .clk(clk), .rst_n(rst_n), .slot(base_q[SLOT_W-1:0]),
        .count(cnt), .advance(rr_adv), .pick(pick)
    );

    // Table and handshake outputs derived from the walk state.
    always_comb begin
        cnt      = bt_data[CNT_W-1:0];
        meta_hit = pg_valid && (pg_lba == cur_lba);
        rr_adv   = (state == S_IDX) && (cnt != '0) && !miss_valid;
        bt_rd    = (state == S_CNT) || ((state == S_IDX) && (cnt != '0));
        bt_addr  = (state == S_CNT) ? base_q
                                    : base_q + BT_AW'(1) + BT_AW'(pick);
        pf_valid = (state == S_ISSUE) && !q_full;
        pf_lba   = tgt_lba;
    end

    // Walk sequencer: a miss re-seeds, otherwise step through the graph.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cur_lba <= '0;
            tgt_lba <= '0;
            base_q  <= '0;
        end else if (miss_valid) begin
            state   <= S_META;
            cur_lba <= miss_lba;
        end else begin
            unique case (state)
                S_IDLE: state <= S_IDLE;
                S_META: if (meta_hit) begin
                    unique case (dec_kind)
                        KIND_ONE: begin
                            tgt_lba <= dec_link;
                            state   <= S_ISSUE;
                        end
                        KIND_FAN: begin
                            base_q <= dec_base;
                            state  <= S_CNT;
                        end
                        default: state <= S_IDLE;
                    endcase
                end
                S_CNT: state <= S_IDX;
                S_IDX: state <= (cnt == '0) ? S_IDLE : S_LBA;
                S_LBA: begin
                    tgt_lba <= bt_data;
                    state   <= S_ISSUE;
                end
                S_ISSUE: if (pf_valid && pf_ready) begin
                    cur_lba <= tgt_lba;
                    state   <= S_META;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgraph_prefetch_chk.sv
// Port-level properties of pgraph_prefetch, attached by bind.
module pgraph_prefetch_chk #(
    parameter int LBA_W = 16,
    parameter int BT_AW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             miss_valid,
    input logic             q_full,
    input logic             pf_valid,
    input logic             pf_ready,
    input logic [LBA_W-1:0] pf_lba,
    input logic             bt_rd,
    input logic [BT_AW-1:0] bt_addr
);
    // R9
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !pf_valid);

    // R10
    hold_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !miss_valid) |=> $stable(pf_lba));

    // R8
    miss_withdraws_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> !pf_valid);

    // R4
    entry_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bt_rd && $past(bt_rd)) |-> (bt_addr > $past(bt_addr)));
endmodule

bind pgraph_prefetch pgraph_prefetch_chk #(.LBA_W(LBA_W), .BT_AW(BT_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .q_full(q_full),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_lba(pf_lba),
    .bt_rd(bt_rd), .bt_addr(bt_addr)
);

// File: tb/pgraph_prefetch_bench.sv
module pgraph_prefetch_bench;
    localparam int LBA_W = 16;
    localparam int BT_AW = 8;

    typedef struct packed {
        logic [15:0] lba;
        logic [1:0]  kind;
        logic [15:0] pay;
        logic        exp_v;
        logic [15:0] exp_lba;
    } vec_t;

    // Loop: 0x200 fans out to 0x300/0x310/0x320, each links back to 0x200.
    localparam vec_t VEC [10] = '{
        '{16'h0100, 2'b01, 16'h0101, 1'b1, 16'h0101},
        '{16'h0101, 2'b01, 16'h0200, 1'b1, 16'h0200},
        '{16'h0200, 2'b10, 16'h0010, 1'b1, 16'h0300},
        '{16'h0300, 2'b01, 16'h0200, 1'b1, 16'h0200},
        '{16'h0200, 2'b10, 16'h0010, 1'b1, 16'h0310},
        '{16'h0310, 2'b01, 16'h0200, 1'b1, 16'h0200},
        '{16'h0200, 2'b10, 16'h0010, 1'b1, 16'h0320},
        '{16'h0320, 2'b01, 16'h0200, 1'b1, 16'h0200},
        '{16'h0200, 2'b10, 16'h0010, 1'b1, 16'h0300},
        '{16'h0300, 2'b00, 16'h0000, 1'b0, 16'h0000}
    };

    logic             clk = 0;
    logic             rst_n = 0;
    logic             miss_valid = 0;
    logic [LBA_W-1:0] miss_lba = '0;
    logic             pg_valid = 0;
    logic [LBA_W-1:0] pg_lba = '0;
    logic [LBA_W+1:0] pg_spare = '0;
    logic             bt_rd;
    logic [BT_AW-1:0] bt_addr;
    logic [LBA_W-1:0] bt_data = '0;
    logic             q_full = 0;
    logic             pf_valid;
    logic             pf_ready = 1;
    logic [LBA_W-1:0] pf_lba;
    logic [LBA_W-1:0] bt_mem [256];
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pgraph_prefetch u_pgraph_prefetch (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_lba(miss_lba),
        .pg_valid(pg_valid), .pg_lba(pg_lba), .pg_spare(pg_spare),
        .bt_rd(bt_rd), .bt_addr(bt_addr), .bt_data(bt_data),
        .q_full(q_full), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_lba(pf_lba)
    );

    // Branch table SRAM model, one cycle read latency.
    always @(posedge clk) if (bt_rd) bt_data <= bt_mem[bt_addr];

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic page(input logic [15:0] lba, input logic [1:0] kind,
                        input logic [15:0] pay);
        @(negedge clk);
        pg_valid = 1; pg_lba = lba; pg_spare = {pay, kind};
        @(negedge clk);
        pg_valid = 0;
    endtask

    task automatic miss(input logic [15:0] lba);
        @(negedge clk);
        miss_valid = 1; miss_lba = lba;
        @(negedge clk);
        miss_valid = 0;
    endtask

    // Poll after a page; on a hit the handshake completes at the next edge.
    task automatic expect_pf(input bit ev, input logic [15:0] el, input string req);
        bit seen = 0;
        logic [15:0] got = '0;
        for (int i = 0; i < 8; i++) begin
            if (pf_valid) begin seen = 1; got = pf_lba; break; end
            @(negedge clk);
        end
        if (ev) check(seen && got == el, req, {15'd0, seen, got}, {16'h1, el});
        else    check(!seen, req, {31'd0, seen}, 32'd0);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) bt_mem[a] = '0;
        bt_mem[8'h10] = 16'd3; bt_mem[8'h11] = 16'h0300;
        bt_mem[8'h12] = 16'h0310; bt_mem[8'h13] = 16'h0320;
        bt_mem[8'h25] = 16'd2; bt_mem[8'h26] = 16'h0900; bt_mem[8'h27] = 16'h0910;
        bt_mem[8'h30] = 16'd0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!pf_valid && !bt_rd, "R1", {30'd0, pf_valid, bt_rd}, 32'd0);
        rst_n = 1;
        // R1 no walk without a seeding miss
        page(16'h0100, 2'b01, 16'h0101);
        expect_pf(0, 16'h0, "R1");

        miss(16'h0100);
        for (int v = 0; v < 10; v++) begin
            page(VEC[v].lba, VEC[v].kind, VEC[v].pay);
            // R3 regular, R4/R5 branch rotation, R7 terminal
            expect_pf(VEC[v].exp_v, VEC[v].exp_lba,
                      VEC[v].kind == 2'b10 ? "R5" : (VEC[v].exp_v ? "R3" : "R7"));
            if (VEC[v].exp_v) @(negedge clk);
        end
        // R7 after terminal, pages are ignored
        page(16'h0300, 2'b01, 16'h0200);
        expect_pf(0, 16'h0, "R7");

        // R6 foreign page ignored
        miss(16'h0500);
        page(16'h0501, 2'b01, 16'h0999);
        expect_pf(0, 16'h0, "R6");
        // R9 full queue suppresses
        q_full = 1;
        page(16'h0500, 2'b01, 16'h0600);
        expect_pf(0, 16'h0, "R9");
        pf_ready = 0; q_full = 0;
        @(negedge clk);
        check(pf_valid && pf_lba == 16'h0600, "R9", {15'd0, pf_valid, pf_lba}, {16'h1, 16'h0600});
        repeat (3) @(negedge clk);
        // R10 held while not ready
        check(pf_valid && pf_lba == 16'h0600, "R10", {15'd0, pf_valid, pf_lba}, {16'h1, 16'h0600});
        pf_ready = 1;
        @(negedge clk);

        // R8 miss withdraws a pending request
        pf_ready = 0;
        page(16'h0600, 2'b01, 16'h0700);
        check(pf_valid && pf_lba == 16'h0700, "R3", {15'd0, pf_valid, pf_lba}, {16'h1, 16'h0700});
        miss(16'h0800);
        check(!pf_valid, "R8", {31'd0, pf_valid}, 32'd0);
        pf_ready = 1;
        // R5 separate list keeps its own rotation
        page(16'h0800, 2'b10, 16'h0025);
        expect_pf(1, 16'h0900, "R5");
        @(negedge clk);
        page(16'h0900, 2'b01, 16'h0800);
        expect_pf(1, 16'h0800, "R2");
        @(negedge clk);
        page(16'h0800, 2'b10, 16'h0025);
        expect_pf(1, 16'h0910, "R5");
        @(negedge clk);
        // R4 zero count ends the walk
        page(16'h0910, 2'b10, 16'h0030);
        expect_pf(0, 16'h0, "R4");
        // R2 reserved kind stops the walk
        miss(16'h0A00);
        page(16'h0A00, 2'b11, 16'h0B00);
        expect_pf(0, 16'h0, "R2");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule